// File: doc/BRIEF.md
# Two-Cell Pack Protection Controller

This block is the digital decision core of a protection circuit for a pack of lithium-ion cells in series. Analog comparators outside the block compare each cell and the current-sense nodes against fixed levels and hand it one flag per condition. From these flags the block decides whether the charge switch and the discharge switch may be on, and whether the pack is in its low-power sleep state.

Cell-voltage flags (above overvoltage, below charge-enable, below undervoltage) are only looked at when a slow sample tick is high. A typical tick period is tens of milliseconds. The overvoltage and undervoltage delays are counted in sample ticks. The overcurrent and charge-detect flags are watched on every clock, and the overcurrent delay is counted in clock cycles. Every fault must persist for its whole delay window. Any qualifying sample or cycle that lacks the fault restarts the window from zero.

Recovery differs by fault:
- Overvoltage is released only when every cell reports being below the lower charge-enable level.
- Undervoltage puts the block to sleep, and only a charge-detect flag wakes it.
- Overcurrent clears as soon as both sense flags are low.
- A pack-disable input turns both switches off and holds the overcurrent timer at zero.

Top module: `pack_guard`

## Requirements
- R1: While rst_n is low and on the first cycle after it, asleep=1 and dsg_en=0. chg_en=1 whenever pack_off=0.
- R2: cell_ov, cell_ce_ok, cell_uv and pin_float have no effect on any output unless smp_tick=1 on that clock edge.
- R3: When any cell_ov bit is 1 on OV_DLY consecutive sample ticks, chg_en goes to 0 one clock after the last of those tick edges. A sample tick with no overvoltage restarts the count from zero.
- R4: pin_float=1 at a sample tick counts exactly as an overvoltage sample.
- R5: After an overvoltage trip, chg_en returns to 1 one clock after a sample tick at which every cell_ce_ok bit is 1, no cell_ov bit is 1 and pin_float=0. It stays 0 at all other times.
- R6: When any cell_uv bit is 1 on UV_DLY consecutive sample ticks, asleep goes to 1 and dsg_en goes to 0 one clock after the last of those tick edges. A tick with no undervoltage restarts the count.
- R7: A clock edge with cd_lo=1 or cd_hi=1 clears asleep, which lets dsg_en return to 1 in the next cycle. This holds even while a cell_uv bit is still 1. The undervoltage count restarts from zero at that edge.
- R8: When oc_lo or oc_hi is 1 on OC_DLY consecutive clock edges, dsg_en is 0 right after the last of those edges. It stays 0 until an edge at which both are 0, and any edge with both at 0 restarts the count.
- R9: While pack_off=1, chg_en=0 and dsg_en=0 in the same cycle, and the overcurrent count is held at zero. After pack_off falls, a full OC_DLY window is needed before an overcurrent trips.
- R10: While asleep=1, dsg_en=0 regardless of the overcurrent and pack-disable inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_tick | input | 1 | One-cycle pulse marking a cell sample point |
| cell_ov | input | N_CELLS | Per cell: voltage above the overvoltage level |
| cell_ce_ok | input | N_CELLS | Per cell: voltage below the charge-enable level |
| cell_uv | input | N_CELLS | Per cell: voltage below the undervoltage level |
| oc_lo | input | 1 | Low-side sense beyond the discharge overcurrent level |
| oc_hi | input | 1 | High-side sense beyond the discharge overcurrent level |
| cd_lo | input | 1 | Low-side sense shows charge-direction offset |
| cd_hi | input | 1 | High-side sense shows charge-direction offset |
| pack_off | input | 1 | External pack disable, active high |
| pin_float | input | 1 | A cell input pin is open |
| chg_en | output | 1 | Charge switch may conduct |
| dsg_en | output | 1 | Discharge switch may conduct |
| asleep | output | 1 | Block is in low-power sleep |

## Verification
A wrong delay counter shows up as a switch that turns off one sample or one clock too early or too late relative to the last qualifying edge. The bench model tracks that edge and catches the error on the very next cycle. A fault latch that sets or clears at the wrong moment shows up on chg_en or asleep one clock after the offending edge. The main hazards are a recovery taken between sample ticks, and sleep failing to clear while an undervoltage flag is still present. A missing hold on the overcurrent timer during pack disable appears as a discharge trip fewer than OC_DLY cycles after pack_off falls.

// File: rtl/pg_pkg.sv
// Package: pg_pkg
// Shared types for the pack protection controller.
// Assumes nothing beyond standard SystemVerilog.
package pg_pkg;

    // Reduced view of all cells at one sample point
    typedef struct packed {
        logic ov_any;   // some cell above overvoltage (or an open pin)
        logic ce_all;   // every cell below the charge-enable level
        logic uv_any;   // some cell below undervoltage
    } cell_view_t;

endpackage

// File: rtl/cell_eval.sv
// Module: cell_eval
// Folds the per-cell comparator flags into a single view of the pack.
// Assumes flags are already synchronous to clk; purely combinational.
module cell_eval
    import pg_pkg::*;
#(
    parameter int N_CELLS = 2
) (
    input  logic [N_CELLS-1:0] cell_ov,
    input  logic [N_CELLS-1:0] cell_ce_ok,
    input  logic [N_CELLS-1:0] cell_uv,
    input  logic               pin_float,
    output cell_view_t         view
);

    logic [N_CELLS:0] ov_chain;
    logic [N_CELLS:0] ce_chain;
    logic [N_CELLS:0] uv_chain;

    assign ov_chain[0] = pin_float;
    assign ce_chain[0] = 1'b1;
    assign uv_chain[0] = 1'b0;

    // One reduction stage per cell
    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        assign ov_chain[i+1] = ov_chain[i] | cell_ov[i];
        assign ce_chain[i+1] = ce_chain[i] & cell_ce_ok[i];
        assign uv_chain[i+1] = uv_chain[i] | cell_uv[i];
    end

    // Pack-level view
    always_comb begin
        view.ov_any = ov_chain[N_CELLS];
        view.ce_all = ce_chain[N_CELLS];
        view.uv_any = uv_chain[N_CELLS];
    end

endmodule

// File: rtl/persist_timer.sv
// Module: persist_timer
// Non-retriggering persistence counter. On each edge with step=1 it counts
// up while cond holds and returns to zero when cond is absent. It saturates
// at LIMIT, and fire is high while the count equals LIMIT. clr has priority
// and zeroes the count on any edge. Assumes LIMIT >= 1.
module persist_timer #(
    parameter int LIMIT = 4,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic cond,
    input  logic clr,
    output logic fire
);

    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count consecutive qualifying steps, restart on a gap or a clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step) begin
            if (!cond)          cnt <= '0;
            else if (cnt < LIM) cnt <= cnt + 1'b1;
        end
    end

    assign fire = (cnt == LIM);

    // Persistence window rules
    assert_cnt_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);
    assert_gap_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cond) |=> (cnt == '0));
    assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !fire);

endmodule

// File: rtl/pack_guard.sv
// Module: pack_guard
// Protection decision core for a series lithium-ion pack. It samples the
// cell flags on smp_tick and runs three persistence timers (overvoltage and
// undervoltage in ticks, overcurrent in clocks). It latches the charge block
// and the sleep state and drives the switch enables. Assumes all inputs are
// synchronous to clk and smp_tick is a one-cycle pulse.
module pack_guard
    import pg_pkg::*;
#(
    parameter int N_CELLS = 2,
    parameter int OV_DLY  = 16,
    parameter int UV_DLY  = 16,
    parameter int OC_DLY  = 1200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_tick,
    input  logic [N_CELLS-1:0] cell_ov,
    input  logic [N_CELLS-1:0] cell_ce_ok,
    input  logic [N_CELLS-1:0] cell_uv,
    input  logic               oc_lo,
    input  logic               oc_hi,
    input  logic               cd_lo,
    input  logic               cd_hi,
    input  logic               pack_off,
    input  logic               pin_float,
    output logic               chg_en,
    output logic               dsg_en,
    output logic               asleep
);

    cell_view_t view;
    logic       ov_fire, uv_fire, oc_fire;
    logic       chg_blk;
    logic       sleep_q;
    logic       chg_seen;
    logic       oc_seen;
    logic       ce_release;

    assign chg_seen   = cd_lo | cd_hi;
    assign oc_seen    = oc_lo | oc_hi;
    assign ce_release = smp_tick & view.ce_all & ~view.ov_any;

    cell_eval #(.N_CELLS(N_CELLS)) u_eval (
        .cell_ov    (cell_ov),
        .cell_ce_ok (cell_ce_ok),
        .cell_uv    (cell_uv),
        .pin_float  (pin_float),
        .view       (view)
    );

    persist_timer #(.LIMIT(OV_DLY)) u_ov_tmr (
        .clk (clk), .rst_n (rst_n), .step (smp_tick),
        .cond (view.ov_any), .clr (1'b0), .fire (ov_fire)
    );

    persist_timer #(.LIMIT(UV_DLY)) u_uv_tmr (
        .clk (clk), .rst_n (rst_n), .step (smp_tick),
        .cond (view.uv_any), .clr (chg_seen), .fire (uv_fire)
    );

    persist_timer #(.LIMIT(OC_DLY)) u_oc_tmr (
        .clk (clk), .rst_n (rst_n), .step (1'b1),
        .cond (oc_seen), .clr (pack_off), .fire (oc_fire)
    );

    // Charge block latch: release at a clean sample, otherwise set on trip
    always_ff @(posedge clk) begin
        if (!rst_n)          chg_blk <= 1'b0;
        else if (ce_release) chg_blk <= 1'b0;
        else if (ov_fire)    chg_blk <= 1'b1;
    end

    // Sleep latch: charge detect wakes, undervoltage trip sleeps
    always_ff @(posedge clk) begin
        if (!rst_n)        sleep_q <= 1'b1;
        else if (chg_seen) sleep_q <= 1'b0;
        else if (uv_fire)  sleep_q <= 1'b1;
    end

    assign chg_en = ~chg_blk & ~pack_off;
    assign dsg_en = ~sleep_q & ~oc_fire & ~pack_off;
    assign asleep = sleep_q;

    // Latch behaviour over time
    assert_blk_only_at_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_blk && !smp_tick) |=> chg_blk);
    assert_wake_on_detect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_seen |=> !asleep);
    assert_sleep_needs_uv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_q) |-> $past(uv_fire));
    assert_blk_needs_ov_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_blk) |-> $past(ov_fire));
    assert_sleep_kills_dsg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !dsg_en);

endmodule

// File: tb/pack_guard_bench.sv
// Bench for pack_guard: a behavioural reference model stepped on every
// rising edge and compared against the outputs on every falling edge,
// plus directed checks at the corner points.
module pack_guard_bench;

    localparam int NC = 2;
    localparam int OVD = 3;
    localparam int UVD = 2;
    localparam int OCD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_tick = 1'b0;
    logic [NC-1:0] cell_ov = '0;
    logic [NC-1:0] cell_ce_ok = '1;
    logic [NC-1:0] cell_uv = '0;
    logic oc_lo = 1'b0, oc_hi = 1'b0, cd_lo = 1'b0, cd_hi = 1'b0;
    logic pack_off = 1'b0, pin_float = 1'b0;
    logic chg_en, dsg_en, asleep;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pack_guard #(.N_CELLS(NC), .OV_DLY(OVD), .UV_DLY(UVD), .OC_DLY(OCD)) u_pack_guard (
        .clk (clk), .rst_n (rst_n), .smp_tick (smp_tick),
        .cell_ov (cell_ov), .cell_ce_ok (cell_ce_ok), .cell_uv (cell_uv),
        .oc_lo (oc_lo), .oc_hi (oc_hi), .cd_lo (cd_lo), .cd_hi (cd_hi),
        .pack_off (pack_off), .pin_float (pin_float),
        .chg_en (chg_en), .dsg_en (dsg_en), .asleep (asleep)
    );

    // Reference model state
    int  m_ov_run = 0, m_uv_run = 0, m_oc_run = 0;
    bit  m_blocked = 0, m_sleep = 1;

    always @(posedge clk) begin
        bit ovs, uvs, ceall, det, ocs, old_ov_trip, old_uv_trip;
        if (!rst_n) begin
            m_ov_run = 0; m_uv_run = 0; m_oc_run = 0;
            m_blocked = 0; m_sleep = 1;
        end else begin
            ovs   = (cell_ov != 0) || pin_float;
            uvs   = (cell_uv != 0);
            ceall = (cell_ce_ok == '1);
            det   = cd_lo || cd_hi;
            ocs   = oc_lo || oc_hi;
            old_ov_trip = (m_ov_run >= OVD);
            old_uv_trip = (m_uv_run >= UVD);
            if (smp_tick && ceall && !ovs) m_blocked = 0;
            else if (old_ov_trip)          m_blocked = 1;
            if (det)              m_sleep = 0;
            else if (old_uv_trip) m_sleep = 1;
            if (smp_tick) m_ov_run = ovs ? ((m_ov_run < OVD) ? m_ov_run + 1 : OVD) : 0;
            if (det) m_uv_run = 0;
            else if (smp_tick) m_uv_run = uvs ? ((m_uv_run < UVD) ? m_uv_run + 1 : UVD) : 0;
            if (pack_off || !ocs) m_oc_run = 0;
            else if (m_oc_run < OCD) m_oc_run++;
        end
    end

    task automatic chk(input bit act, input bit exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(chg_en, !m_blocked && !pack_off, cur_req, "chg_en vs model");
            chk(dsg_en, !m_sleep && (m_oc_run < OCD) && !pack_off, cur_req, "dsg_en vs model");
            chk(asleep, m_sleep, cur_req, "asleep vs model");
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    // One sample point followed by two quiet cycles
    task automatic tick;
        smp_tick = 1'b1;
        cyc(1);
        smp_tick = 1'b0;
        cyc(2);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finished = 1'b1;
        summary();
    end

    initial begin
        cyc(3);
        @(negedge clk);
        chk(asleep, 1'b1, "R1", "asleep in reset");
        chk(dsg_en, 1'b0, "R1", "dsg_en in reset");
        rst_n = 1'b1;
        cyc(1);
        chk(asleep, 1'b1, "R1", "asleep after reset");
        chk(chg_en, 1'b1, "R1", "chg_en after reset");

        // Wake from sleep via low-side charge detect
        cur_req = "R7";
        cd_lo = 1; cyc(1); cd_lo = 0;
        chk(dsg_en, 1'b1, "R7", "dsg_en after detect");

        // Overvoltage flags between ticks are ignored
        cur_req = "R2";
        cell_ov = 2'b10; cell_uv = 2'b01; cyc(20);
        cell_ov = 0; cell_uv = 0;
        chk(chg_en, 1'b1, "R2", "chg_en with ov between ticks");
        chk(asleep, 1'b0, "R2", "asleep with uv between ticks");

        // Non-retriggering: a clean tick restarts the window
        cur_req = "R3";
        cell_ov = 2'b10; tick(); tick();
        cell_ov = 0; cell_ce_ok = 2'b01; tick();
        cell_ov = 2'b01; tick(); tick();
        chk(chg_en, 1'b1, "R3", "chg_en after interrupted window");
        tick();
        chk(chg_en, 1'b0, "R3", "chg_en after full window");

        // Release needs all cells below charge-enable
        cur_req = "R5";
        cell_ov = 0; cell_ce_ok = 2'b01; tick();
        chk(chg_en, 1'b0, "R5", "chg_en with one cell above ce");
        cell_ce_ok = 2'b11; cyc(4);
        chk(chg_en, 1'b0, "R5", "chg_en before a tick");
        tick();
        chk(chg_en, 1'b1, "R5", "chg_en after clean tick");

        // Open pin acts as overvoltage
        cur_req = "R4";
        pin_float = 1; tick(); tick(); tick();
        chk(chg_en, 1'b0, "R4", "chg_en with floating pin");
        pin_float = 0; tick();
        chk(chg_en, 1'b1, "R4", "chg_en after pin restored");

        // Undervoltage puts the block to sleep
        cur_req = "R6";
        cell_uv = 2'b01; tick();
        chk(asleep, 1'b0, "R6", "asleep after one uv sample");
        smp_tick = 1; cyc(1); smp_tick = 0;
        chk(asleep, 1'b0, "R6", "asleep on trip edge");
        cyc(1);
        chk(asleep, 1'b1, "R6", "asleep after uv window");
        chk(dsg_en, 1'b0, "R6", "dsg_en in sleep");

        // Sleep forces discharge off even with overcurrent gone
        cur_req = "R10";
        oc_hi = 1; cyc(8); oc_hi = 0; cyc(2);
        chk(dsg_en, 1'b0, "R10", "dsg_en while asleep");

        // Wake with undervoltage still present; uv window restarts
        cur_req = "R7";
        cd_hi = 1; cyc(1); cd_hi = 0;
        chk(asleep, 1'b0, "R7", "asleep after detect with uv");
        tick();
        chk(asleep, 1'b0, "R7", "asleep one uv tick after wake");
        cell_uv = 0; cd_lo = 1; cyc(1); cd_lo = 0;

        // Overcurrent persistence and recovery
        cur_req = "R8";
        oc_lo = 1; cyc(3); oc_lo = 0; cyc(1);
        chk(dsg_en, 1'b1, "R8", "dsg_en after short burst");
        oc_lo = 1; cyc(3);
        chk(dsg_en, 1'b1, "R8", "dsg_en one before trip");
        cyc(1);
        chk(dsg_en, 1'b0, "R8", "dsg_en at trip");
        oc_lo = 0; oc_hi = 1; cyc(2);
        chk(dsg_en, 1'b0, "R8", "dsg_en while high side persists");
        oc_hi = 0; cyc(1);
        chk(dsg_en, 1'b1, "R8", "dsg_en after both clear");

        // Pack disable holds the overcurrent timer
        cur_req = "R9";
        oc_hi = 1; pack_off = 1; #1;
        chk(chg_en, 1'b0, "R9", "chg_en under disable");
        chk(dsg_en, 1'b0, "R9", "dsg_en under disable");
        cyc(10); pack_off = 0; cyc(3);
        chk(dsg_en, 1'b1, "R9", "dsg_en three clocks after release");
        cyc(1);
        chk(dsg_en, 1'b0, "R9", "dsg_en full window after release");
        oc_hi = 0; cyc(2);

        // Mixed stimulus compared against the model every cycle
        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            smp_tick   = ($urandom_range(0, 3) == 0);
            cell_ov    = NC'($urandom_range(0, 7) == 0 ? $urandom : 0);
            cell_ce_ok = NC'($urandom_range(0, 1) == 0 ? '1 : $urandom);
            cell_uv    = NC'($urandom_range(0, 5) == 0 ? $urandom : 0);
            oc_lo      = ($urandom_range(0, 3) == 0);
            oc_hi      = ($urandom_range(0, 5) == 0);
            cd_lo      = ($urandom_range(0, 30) == 0);
            cd_hi      = ($urandom_range(0, 30) == 0);
            pack_off   = ($urandom_range(0, 20) == 0);
            pin_float  = ($urandom_range(0, 25) == 0);
            cyc(1);
        end

        finished = 1'b1;
        summary();
    end

endmodule